// File: doc/BRIEF.md
# Two-Tap Averaging Handshake Filter

This block is a streaming filter with four-phase request/acknowledge channels on both sides. Data travels bundled with its request. Each accepted sample `x` yields one output, `(x + y) / 2`, where `y` is the sample accepted before it; `y` is zero after reset. Once the result has been handed to the consumer, `x` becomes the new `y`.

A small controller runs the datapath. It sequences four internal request/acknowledge pairs: a level-sensitive latch for the incoming sample, a level-sensitive latch for the previous sample, an adder with a matched delay, and the output holding latch. Every pair completes a full four-phase cycle. The controller uses an internal phase state to tell the evaluation half of a transaction from its return-to-zero half. The whole block is modelled on a simulation clock, and the adder delay is counted in clock cycles.

Top module: `avg_hs_ctrl`

## Requirements
- R1: While reset is active and right after it, `in_ack` and `out_req` are 0, `out_data` is 0, and the stored previous sample is 0.
- R2: The first sample after reset produces `x >> 1`, since the previous sample starts at zero.
- R3: Each output equals the low W bits of the (W+1)-bit sum `x + y` shifted right by one. The division truncates and the sum cannot overflow (255 and 255 give 255 at W=8).
- R4: After each completed transaction the previous sample becomes the sample just processed.
- R5: `in_ack` rises only after the incoming sample has been captured. Changes to `in_data` after `in_ack` rises have no effect on the result.
- R6: `out_req` rises exactly ADD_DLY+1 clock cycles after `in_ack` rises, because the adder acknowledge takes ADD_DLY cycles.
- R7: `out_data` does not change while `out_req` is high.
- R8: `out_req` falls only after `out_ack` has risen. `in_ack` stays high until `in_req` and `out_ack` are both low and the internal channels have returned to zero. Only after that is a new `in_req` accepted.
- R9: Reset during a transaction returns the block to idle, clears the previous sample, and the next transaction behaves like the first after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Simulation clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_req | input | 1 | Input request; `in_data` is valid while high |
| in_ack | output | 1 | Input acknowledge |
| in_data | input | W | Input sample, unsigned |
| out_req | output | 1 | Output request; `out_data` is valid while high |
| out_ack | input | 1 | Output acknowledge from the consumer |
| out_data | output | W | Filtered result |

## Verification
The bench scrambles `in_data` as soon as `in_ack` rises. A design that kept the sample latch transparent too long would then average garbage. It also feeds two maximum samples in a row, which catches a sum that wraps at W bits and so gives 127 instead of 255. A slow consumer holds `out_req` high for several cycles to show that the result stays put, and a producer that keeps `in_req` high must see `in_ack` held high rather than a second sample being accepted. A reset in the middle of a transaction is followed by a sample whose expected value assumes the previous sample was cleared; a design that kept the stale value would give the wrong output.

// File: rtl/avg_hs_ctrl.sv
module avg_hs_ctrl #(
  parameter int W       = 8,
  parameter int ADD_DLY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_req,
  output logic         in_ack,
  input  logic [W-1:0] in_data,
  output logic         out_req,
  input  logic         out_ack,
  output logic [W-1:0] out_data
);
  localparam int CW = (ADD_DLY < 2) ? 1 : $clog2(ADD_DLY);

  typedef enum logic [2:0] {S_IDLE, S_XCAP, S_ADD, S_OUTW, S_YCP, S_RTZ} phase_t;
  phase_t st;

  logic         rx, ax, ry, ay, ra, aa;
  logic [W-1:0] x_q, y_q;
  logic [CW-1:0] cnt;
  logic [W:0]   sum;

  assign sum = {1'b0, x_q} + {1'b0, y_q};

  // sample latch: transparent while rx
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      x_q <= '0;
      ax  <= 1'b0;
    end else begin
      if (rx) x_q <= in_data;
      ax <= rx;
    end

  // previous-sample latch: transparent while ry
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      y_q <= '0;
      ay  <= 1'b0;
    end else begin
      if (ry) y_q <= x_q;
      ay <= ry;
    end

  // adder with matched delay
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      aa  <= 1'b0;
    end else if (!ra) begin
      cnt <= '0;
      aa  <= 1'b0;
    end else if (!aa) begin
      if (cnt == CW'(ADD_DLY - 1)) aa <= 1'b1;
      else cnt <= cnt + 1'b1;
    end

  // handshake controller
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      rx       <= 1'b0;
      ry       <= 1'b0;
      ra       <= 1'b0;
      in_ack   <= 1'b0;
      out_req  <= 1'b0;
      out_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_req) begin
          rx <= 1'b1;
          st <= S_XCAP;
        end
        S_XCAP: if (ax) begin
          rx     <= 1'b0;
          in_ack <= 1'b1;
          ra     <= 1'b1;
          st     <= S_ADD;
        end
        S_ADD: if (aa) begin
          out_data <= sum[W:1];
          out_req  <= 1'b1;
          st       <= S_OUTW;
        end
        S_OUTW: if (out_ack) begin
          out_req <= 1'b0;
          ra      <= 1'b0;
          ry      <= 1'b1;
          st      <= S_YCP;
        end
        S_YCP: if (ay) begin
          ry <= 1'b0;
          st <= S_RTZ;
        end
        S_RTZ: if (!in_req && !out_ack && !ax && !aa && !ay) begin
          in_ack <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end

  // R7
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> $stable(out_data));

  // R8
  out_req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> $past(out_ack));

  // R8
  in_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> (!$past(in_req) && !$past(out_ack)));

  // R5
  in_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(ax));

  // R6
  out_req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> ($past(aa) && in_ack));

  // R4
  y_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ay) |-> (y_q == x_q));
endmodule

// File: tb/avg_hs_ctrl_tb.sv
module avg_hs_ctrl_tb;
  localparam int W = 8;
  localparam int ADD_DLY = 3;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [W-1:0] VX [NV] = '{8'd10, 8'd20, 8'd255, 8'd255, 8'd0, 8'd1, 8'd3, 8'd128};
  localparam logic [W-1:0] VE [NV] = '{8'd5, 8'd15, 8'd137, 8'd255, 8'd127, 8'd0, 8'd2, 8'd65};

  logic clk = 0, rst_n = 0, in_req = 0, out_ack = 0;
  logic in_ack, out_req;
  logic [W-1:0] in_data = '0, out_data;
  int tests = 0, fails = 0, cyc = 0;

  avg_hs_ctrl #(.W(W), .ADD_DLY(ADD_DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample(input logic [W-1:0] x, input logic [W-1:0] e, input string tag,
                        input int hold, input bit keep_req);
    int n;
    @(negedge clk);
    in_data = x;
    in_req = 1;
    while (!in_ack) @(negedge clk);
    chk("R5 out_req low at in_ack", out_req, 0);
    if (!keep_req) begin
      in_req = 0;
      in_data = ~x;
    end else in_data = ~x;
    n = 0;
    while (!out_req) begin @(negedge clk); n++; end
    chk("R6 in_ack to out_req cycles", n, ADD_DLY + 1);
    chk(tag, out_data, e);
    for (int i = 0; i < hold; i++) @(negedge clk);
    chk("R7 out_data held", out_data, e);
    chk("R8 out_req held before ack", out_req, 1);
    out_ack = 1;
    while (out_req) @(negedge clk);
    out_ack = 0;
    if (keep_req) begin
      for (int i = 0; i < 6; i++) @(negedge clk);
      chk("R8 in_ack held while in_req high", in_ack, 1);
      chk("R8 no new out_req", out_req, 0);
      in_req = 0;
    end
    while (in_ack) @(negedge clk);
  endtask

  initial begin
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in_ack in reset", in_ack, 0);
    chk("R1 out_req in reset", out_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_data after reset", out_data, 0);
    chk("R1 in_ack after reset", in_ack, 0);

    // vector table: first entry covers R2, later ones R3 and R4
    for (int k = 0; k < NV; k++)
      sample(VX[k], VE[k], (k == 0) ? "R2 first output" : "R3 R4 average", 0, 0);

    // slow consumer
    sample(8'd50, 8'd89, "R3 slow consumer", 5, 0);
    // producer holding in_req high
    sample(8'd70, 8'd60, "R8 held request", 0, 1);
    sample(8'd6, 8'd38, "R4 after held request", 0, 0);

    // reset mid-transaction
    @(negedge clk);
    in_data = 8'd200;
    in_req = 1;
    while (!in_ack) @(negedge clk);
    in_req = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R9 in_ack cleared", in_ack, 0);
    chk("R9 out_req cleared", out_req, 0);
    rst_n = 1;
    sample(8'd100, 8'd50, "R9 previous sample cleared", 0, 0);
    sample(8'd9, 8'd54, "R4 after reset", 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule